// File: doc/BRIEF.md
# Posted Write Clock-Domain Register Bridge

This block sits between a fast bus clock and a slower functional clock in front of a bank of timer registers. Ten registers are carried across the clock boundary. In posted mode, a bus write to one of them completes in the cycle it is presented. The value is then carried into the functional domain by a toggle handshake. While that transfer is in flight, the register's bit in a readable pending bitmap stays set, and software polls that bitmap before it touches the register again.

In non-posted mode, a write to one of those registers holds the bus (ready low) until the value has landed in the functional domain and the acknowledge has come back. Some registers never pass through the bridge: the interface-control register, which holds the posted-mode bit, and the wakeup-enable register. They are written directly in the bus domain. Reads of the live counter and of the capture value go through a request/acknowledge snapshot, so a multi-bit value is never sampled while it is changing. The timer logic itself lives outside this block.

Bus register map, by word address:
- 0..9 are the bridged registers. Index 1 is the counter.
- 10 is the pending bitmap.
- 11 is interface control.
- 12 is wakeup enable.
- 13 is capture.
- 14 and 15 are unused.

Top module: `posted_reg_bridge`

## Requirements
- R1: After reset, interface control (address 11) reads 0x4 (posted mode on), the pending bitmap (address 10) reads 0, the bridged registers and wakeup enable read 0, and every functional-side register output and load pulse is 0.
- R2: In posted mode, a write to a bridged register with index i (address 0..9) is accepted with ready high in the cycle it is presented, and bit i of the pending bitmap reads 1 immediately after the accepting edge.
- R3: With two synchronizer stages, the written value appears on functional slice i, together with a one-cycle load pulse on bit i, at the third funcClk rising edge after the accepting bus edge and not earlier. Pending bit i clears at the second busClk rising edge after that funcClk edge.
- R4: A write to a bridged register whose pending bit is set is held with ready low until the bit clears. The value in flight is never overwritten: when the second write is accepted, the functional slice already holds the first value, and it later holds the second.
- R5: Transfers to different bridged registers run independently, and several pending bits can be set at once.
- R6: Bit 2 of interface control selects posted (1) or non-posted (0) mode. It takes effect on the next access, the other bits read 0, and the register is written without any pending bit.
- R7: In non-posted mode, a write to a bridged register keeps ready low until the transfer has completed. When ready rises, the value is already on the functional slice and the pending bitmap reads 0.
- R8: Wakeup enable (address 12) is written directly, reads back and drives `wakeEn` in the next cycle, and never sets a pending bit. Writes to the pending bitmap (10) and to capture (13) have no effect.
- R9: A read of address 1 returns a snapshot of `funcCounter`, and a read of address 13 returns a snapshot of `funcCapture`. Each snapshot is taken in the functional domain, and ready stays low until it has returned.
- R10: A read of bridged registers other than the counter returns the last value written, without waiting. A write to index 1 still reaches functional slice 1, but a read of address 1 returns the live counter.
- R11: Addresses 14 and 15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus (interface) clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| busReq | input | 1 | Access request; held stable until busReady |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register word address |
| busWData | input | DATA_W | Write data |
| busReady | output | 1 | Access completes at the edge where busReq and busReady are both high |
| busRData | output | DATA_W | Read data, valid while busReady is high for a read |
| wakeEn | output | DATA_W | Wakeup-enable register value |
| funcClk | input | 1 | Functional clock |
| funcRstN | input | 1 | Active-low asynchronous reset, functional domain |
| funcCounter | input | DATA_W | Live counter value from the timer |
| funcCapture | input | DATA_W | Capture value from the timer |
| funcRegs | output | 10*DATA_W | Bridged register values, slice i at [i*DATA_W +: DATA_W] |
| funcLoad | output | 10 | One-funcClk pulse per slice when a new value lands |

## Verification
The results that stay in the bus domain come at fixed times. Ready is combinational within the presenting cycle, and a pending bit reads set right after the accepting edge. The results that cross the boundary are counted in edges of the receiving clock: a value lands on the third funcClk edge, and its pending bit clears on the second busClk edge after that. The bench counts exactly those edges and samples half a nanosecond after each one. The two clocks have rising edges at even and odd nanoseconds respectively, so a sample never sits on an edge of either clock. Stalls whose length depends on the phase between the clocks, such as non-posted writes, snapshot reads and held-off writes, are checked by waiting for ready within a bounded count and then checking the state the requirement fixes at that moment.

// File: rtl/pbridge_pkg.sv
package pbridge_pkg;

  // Fixed register map: the pending bitmap bit order follows the bridged index.
  localparam int NUM_POSTED  = 10;
  localparam int COUNTER_IDX = 1;
  localparam int PEND_ADDR   = 10;
  localparam int IFCTRL_ADDR = 11;
  localparam int WAKE_ADDR   = 12;
  localparam int CAPT_ADDR   = 13;
  localparam int POSTED_BIT  = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_WR,
    ST_WAIT_RD
  } ctrlState_t;

  // Strobes from control to datapath, valid for one busClk cycle.
  typedef struct packed {
    logic launchWr;     // start a cross-domain transfer for busAddr
    logic snapLaunch;   // start a snapshot request
    logic snapSelCapt;  // snapshot source: 1 capture, 0 counter
    logic ifCtrlWr;     // direct write of interface control
    logic wakeWr;       // direct write of wakeup enable
  } strobe_t;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/xfer_lane.sv
module xfer_lane #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              launch,
  input  logic [DATA_W-1:0] wrData,
  output logic              pending,
  output logic [DATA_W-1:0] shadow,
  input  logic              funcClk,
  input  logic              funcRstN,
  output logic [DATA_W-1:0] funcValue,
  output logic              funcLoad
);

  logic              reqTgl;
  logic [DATA_W-1:0] holdReg;
  logic              ackSync;
  logic              reqSync;
  logic              seenTgl;

  // Bus side: hold the value and flip the request toggle.
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqTgl  <= 1'b0;
      holdReg <= '0;
    end else if (launch) begin
      reqTgl  <= ~reqTgl;
      holdReg <= wrData;
    end
  end

  bit_sync #(.STAGES(STAGES)) i_reqSync (
    .clk(funcClk), .rstN(funcRstN), .din(reqTgl), .dout(reqSync)
  );

  // Functional side: take the value once the toggle arrives, then echo it back.
  always_ff @(posedge funcClk or negedge funcRstN) begin
    if (!funcRstN) begin
      seenTgl   <= 1'b0;
      funcValue <= '0;
      funcLoad  <= 1'b0;
    end else begin
      funcLoad <= 1'b0;
      if (reqSync != seenTgl) begin
        seenTgl   <= reqSync;
        funcValue <= holdReg;
        funcLoad  <= 1'b1;
      end
    end
  end

  bit_sync #(.STAGES(STAGES)) i_ackSync (
    .clk(busClk), .rstN(busRstN), .din(seenTgl), .dout(ackSync)
  );

  assign pending = reqTgl ^ ackSync;
  assign shadow  = holdReg;

  // R4: control never launches into a busy lane.
  p_no_launch_busy_r4: assert property (@(posedge busClk) disable iff (!busRstN)
    launch |-> !pending);

  // R4: the value in flight stays put while the lane is busy.
  p_hold_stable_r4: assert property (@(posedge busClk) disable iff (!busRstN)
    pending |=> $stable(holdReg));

  // R2: a pending bit only rises after a launch.
  p_pend_rise_r2: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(pending) |-> $past(launch));

  // R3: the load pulse lasts one functional cycle.
  p_load_single_r3: assert property (@(posedge funcClk) disable iff (!funcRstN)
    funcLoad |=> !funcLoad);

endmodule

// File: rtl/pbridge_ctrl.sv
module pbridge_ctrl
  import pbridge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                  busClk,
  input  logic                  busRstN,
  input  logic                  busReq,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [NUM_POSTED-1:0] pending,
  input  logic                  postedMode,
  input  logic                  snapDone,
  output logic                  busReady,
  output strobe_t               strobe
);

  ctrlState_t state, stateNext;
  logic hit;
  logic isPosted;
  logic isSnapRd;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_POSTED; i++)
      if (busAddr == ADDR_W'(i)) hit = pending[i];
  end

  assign isPosted = busAddr < ADDR_W'(NUM_POSTED);
  assign isSnapRd = !busWe && (busAddr == ADDR_W'(COUNTER_IDX) ||
                               busAddr == ADDR_W'(CAPT_ADDR));

  always_comb begin
    stateNext = state;
    busReady  = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (busReq) begin
          if (busWe && isPosted) begin
            if (!hit) begin
              strobe.launchWr = 1'b1;
              if (postedMode) busReady  = 1'b1;
              else            stateNext = ST_WAIT_WR;
            end
          end else if (busWe) begin
            busReady        = 1'b1;
            strobe.ifCtrlWr = busAddr == ADDR_W'(IFCTRL_ADDR);
            strobe.wakeWr   = busAddr == ADDR_W'(WAKE_ADDR);
          end else if (isSnapRd) begin
            strobe.snapLaunch  = 1'b1;
            strobe.snapSelCapt = busAddr == ADDR_W'(CAPT_ADDR);
            stateNext          = ST_WAIT_RD;
          end else begin
            busReady = 1'b1;
          end
        end
      end
      ST_WAIT_WR: begin
        busReady = !hit;
        if (!hit) stateNext = ST_IDLE;
      end
      ST_WAIT_RD: begin
        busReady = snapDone;
        if (snapDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) state <= ST_IDLE;
    else          state <= stateNext;
  end

  // R9: a new snapshot is only requested once the previous one has returned.
  p_snap_idle_r9: assert property (@(posedge busClk) disable iff (!busRstN)
    strobe.snapLaunch |-> snapDone);

endmodule

// File: rtl/pbridge_datapath.sv
module pbridge_datapath
  import pbridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int STAGES = 2
) (
  input  logic                         busClk,
  input  logic                         busRstN,
  input  strobe_t                      strobe,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWData,
  output logic [NUM_POSTED-1:0]        pending,
  output logic                         postedMode,
  output logic                         snapDone,
  output logic [DATA_W-1:0]            rdData,
  output logic [DATA_W-1:0]            wakeEn,
  input  logic                         funcClk,
  input  logic                         funcRstN,
  input  logic [DATA_W-1:0]            funcCounter,
  input  logic [DATA_W-1:0]            funcCapture,
  output logic [NUM_POSTED*DATA_W-1:0] funcRegs,
  output logic [NUM_POSTED-1:0]        funcLoad
);

  logic [DATA_W-1:0] shadowArr [NUM_POSTED];

  for (genvar g = 0; g < NUM_POSTED; g++) begin : g_lane
    logic laneLaunch;
    assign laneLaunch = strobe.launchWr && (busAddr == ADDR_W'(g));
    xfer_lane #(.DATA_W(DATA_W), .STAGES(STAGES)) i_lane (
      .busClk   (busClk),
      .busRstN  (busRstN),
      .launch   (laneLaunch),
      .wrData   (busWData),
      .pending  (pending[g]),
      .shadow   (shadowArr[g]),
      .funcClk  (funcClk),
      .funcRstN (funcRstN),
      .funcValue(funcRegs[g*DATA_W +: DATA_W]),
      .funcLoad (funcLoad[g])
    );
  end

  // Directly written bus-domain registers.
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      postedMode <= 1'b1;
      wakeEn     <= '0;
    end else begin
      if (strobe.ifCtrlWr) postedMode <= busWData[POSTED_BIT];
      if (strobe.wakeWr)   wakeEn     <= busWData;
    end
  end

  // Snapshot handshake for counter and capture reads.
  logic              snapReq, snapSel, snapReqF, snapSeen, snapAck;
  logic [DATA_W-1:0] snapVal;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      snapReq <= 1'b0;
      snapSel <= 1'b0;
    end else if (strobe.snapLaunch) begin
      snapReq <= ~snapReq;
      snapSel <= strobe.snapSelCapt;
    end
  end

  bit_sync #(.STAGES(STAGES)) i_snapReqSync (
    .clk(funcClk), .rstN(funcRstN), .din(snapReq), .dout(snapReqF)
  );

  always_ff @(posedge funcClk or negedge funcRstN) begin
    if (!funcRstN) begin
      snapSeen <= 1'b0;
      snapVal  <= '0;
    end else if (snapReqF != snapSeen) begin
      snapSeen <= snapReqF;
      snapVal  <= snapSel ? funcCapture : funcCounter;
    end
  end

  bit_sync #(.STAGES(STAGES)) i_snapAckSync (
    .clk(busClk), .rstN(busRstN), .din(snapSeen), .dout(snapAck)
  );

  assign snapDone = snapReq == snapAck;

  // Read mux.
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_POSTED; i++)
      if (busAddr == ADDR_W'(i))
        rdData = (i == COUNTER_IDX) ? snapVal : shadowArr[i];
    if (busAddr == ADDR_W'(PEND_ADDR))   rdData = DATA_W'(pending);
    if (busAddr == ADDR_W'(IFCTRL_ADDR)) rdData[POSTED_BIT] = postedMode;
    if (busAddr == ADDR_W'(WAKE_ADDR))   rdData = wakeEn;
    if (busAddr == ADDR_W'(CAPT_ADDR))   rdData = snapVal;
  end

  // R9: a returned snapshot cannot move under the bus in the following cycle.
  p_snap_stable_r9: assert property (@(posedge busClk) disable iff (!busRstN || !funcRstN)
    snapDone |=> $stable(snapVal));

endmodule

// File: rtl/posted_reg_bridge.sv
module posted_reg_bridge
  import pbridge_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         busClk,
  input  logic                         busRstN,
  input  logic                         busReq,
  input  logic                         busWe,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWData,
  output logic                         busReady,
  output logic [DATA_W-1:0]            busRData,
  output logic [DATA_W-1:0]            wakeEn,
  input  logic                         funcClk,
  input  logic                         funcRstN,
  input  logic [DATA_W-1:0]            funcCounter,
  input  logic [DATA_W-1:0]            funcCapture,
  output logic [NUM_POSTED*DATA_W-1:0] funcRegs,
  output logic [NUM_POSTED-1:0]        funcLoad
);

  strobe_t               strobe;
  logic [NUM_POSTED-1:0] pending;
  logic                  postedMode;
  logic                  snapDone;

  pbridge_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busClk    (busClk),
    .busRstN   (busRstN),
    .busReq    (busReq),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .pending   (pending),
    .postedMode(postedMode),
    .snapDone  (snapDone),
    .busReady  (busReady),
    .strobe    (strobe)
  );

  pbridge_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAGES(SYNC_STAGES)) i_dp (
    .busClk     (busClk),
    .busRstN    (busRstN),
    .strobe     (strobe),
    .busAddr    (busAddr),
    .busWData   (busWData),
    .pending    (pending),
    .postedMode (postedMode),
    .snapDone   (snapDone),
    .rdData     (busRData),
    .wakeEn     (wakeEn),
    .funcClk    (funcClk),
    .funcRstN   (funcRstN),
    .funcCounter(funcCounter),
    .funcCapture(funcCapture),
    .funcRegs   (funcRegs),
    .funcLoad   (funcLoad)
  );

endmodule

// File: tb/test_posted_reg_bridge.sv
`timescale 1ns/100ps
module test_posted_reg_bridge;

  logic         busClk = 1'b0;
  logic         funcClk = 1'b0;
  logic         busRstN, funcRstN;
  logic         busReq, busWe;
  logic [3:0]   busAddr;
  logic [31:0]  busWData;
  logic         busReady;
  logic [31:0]  busRData;
  logic [31:0]  wakeEn;
  logic [31:0]  funcCounter, funcCapture;
  logic [319:0] funcRegs;
  logic [9:0]   funcLoad;

  int checks = 0;
  int failures = 0;

  posted_reg_bridge i_posted_reg_bridge (
    .busClk(busClk), .busRstN(busRstN), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWData(busWData), .busReady(busReady),
    .busRData(busRData), .wakeEn(wakeEn), .funcClk(funcClk),
    .funcRstN(funcRstN), .funcCounter(funcCounter), .funcCapture(funcCapture),
    .funcRegs(funcRegs), .funcLoad(funcLoad)
  );

  // 250 MHz bus clock, rising edges at even ns; functional clock rises at odd ns.
  always #2 busClk = ~busClk;
  initial begin
    #7 funcClk = 1'b1;
    forever #7 funcClk = ~funcClk;
  end

  function automatic logic [31:0] slice(input int i);
    return funcRegs[i*32 +: 32];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d, output int stalls);
    stalls = 0;
    @(negedge busClk);
    busReq = 1'b1; busWe = 1'b1; busAddr = a; busWData = d;
    #0.5;
    while (!busReady && stalls < 500) begin
      @(negedge busClk); #0.5; stalls++;
    end
    @(posedge busClk); #0.5;
    busReq = 1'b0; busWe = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [31:0] d, output int stalls);
    stalls = 0;
    @(negedge busClk);
    busReq = 1'b1; busWe = 1'b0; busAddr = a;
    #0.5;
    while (!busReady && stalls < 500) begin
      @(negedge busClk); #0.5; stalls++;
    end
    d = busRData;
    @(posedge busClk); #0.5;
    busReq = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    int s;
    for (int n = 0; n < 200; n++) begin
      doRead(4'd10, d, s);
      if (d == 32'h0) return;
    end
    check(1'b0, "R3", "pending bitmap never cleared", d, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] d;
    int s;
    doRead(4'd11, d, s); check(d == 32'h4, "R1", "ifctrl after reset", d, 32'h4);
    doRead(4'd10, d, s); check(d == 32'h0, "R1", "pending after reset", d, 32'h0);
    doRead(4'd0, d, s);  check(d == 32'h0, "R1", "reg0 after reset", d, 32'h0);
    check(funcRegs == '0, "R1", "func regs after reset", funcRegs[31:0], 32'h0);
    check(funcLoad == '0, "R1", "load pulses after reset", 32'(funcLoad), 32'h0);
    check(wakeEn == '0, "R1", "wakeup after reset", wakeEn, 32'h0);
  endtask

  task automatic testTiming();
    int s;
    doWrite(4'd0, 32'hA5A5_0001, s);
    check(s == 0, "R2", "posted write stalls", 32'(s), 32'h0);
    busReq = 1'b1; busWe = 1'b0; busAddr = 4'd10;
    #0.5;
    check(busRData[0] == 1'b1, "R2", "pending bit 0 after accept", busRData, 32'h1);
    repeat (2) @(posedge funcClk);
    #0.5;
    check(slice(0) == 32'h0 && !funcLoad[0], "R3", "value early", slice(0), 32'h0);
    @(posedge funcClk); #0.5;
    check(slice(0) == 32'hA5A5_0001, "R3", "value at 3rd func edge", slice(0), 32'hA5A5_0001);
    check(funcLoad[0] == 1'b1, "R3", "load pulse", 32'(funcLoad), 32'h1);
    check(busRData[0] == 1'b1, "R3", "pending after landing", busRData, 32'h1);
    @(posedge busClk); #0.5;
    check(busRData[0] == 1'b1, "R3", "pending after 1st bus edge", busRData, 32'h1);
    @(posedge busClk); #0.5;
    check(busRData[0] == 1'b0, "R3", "pending after 2nd bus edge", busRData, 32'h0);
    @(posedge funcClk); #0.5;
    check(funcLoad[0] == 1'b0, "R3", "load pulse end", 32'(funcLoad), 32'h0);
    busReq = 1'b0;
  endtask

  task automatic testHoldOff();
    int s;
    doWrite(4'd2, 32'h1111_2222, s);
    doWrite(4'd2, 32'h3333_4444, s);
    check(s > 0, "R4", "second write held off", 32'(s), 32'h1);
    check(slice(2) == 32'h1111_2222, "R4", "first value landed", slice(2), 32'h1111_2222);
    waitIdle();
    check(slice(2) == 32'h3333_4444, "R4", "second value landed", slice(2), 32'h3333_4444);
  endtask

  task automatic testMulti();
    logic [31:0] d;
    int s;
    doWrite(4'd3, 32'h33, s);
    doWrite(4'd4, 32'h44, s);
    doWrite(4'd5, 32'h55, s);
    doRead(4'd10, d, s);
    check(d == 32'h38, "R5", "three pending bits", d, 32'h38);
    waitIdle();
    check(slice(3) == 32'h33 && slice(4) == 32'h44 && slice(5) == 32'h55,
          "R5", "three values landed", slice(4), 32'h44);
  endtask

  task automatic testNonPosted();
    logic [31:0] d;
    int s;
    doWrite(4'd11, 32'hFFFF_FFFF, s);
    doRead(4'd11, d, s); check(d == 32'h4, "R6", "ifctrl other bits", d, 32'h4);
    doWrite(4'd11, 32'h0, s);
    doRead(4'd11, d, s); check(d == 32'h0, "R6", "ifctrl cleared", d, 32'h0);
    doWrite(4'd6, 32'hBEEF_0006, s);
    check(s >= 3, "R7", "non-posted write stalls", 32'(s), 32'h3);
    check(slice(6) == 32'hBEEF_0006, "R7", "value landed before ready", slice(6), 32'hBEEF_0006);
    doRead(4'd10, d, s); check(d == 32'h0, "R7", "pending after non-posted", d, 32'h0);
    doWrite(4'd11, 32'h4, s);
    doWrite(4'd7, 32'h77, s);
    check(s == 0, "R6", "posted mode restored", 32'(s), 32'h0);
    waitIdle();
  endtask

  task automatic testDirect();
    logic [31:0] d;
    int s;
    doWrite(4'd12, 32'h0000_1234, s);
    check(wakeEn == 32'h1234, "R8", "wakeup output", wakeEn, 32'h1234);
    doRead(4'd12, d, s); check(d == 32'h1234, "R8", "wakeup readback", d, 32'h1234);
    doRead(4'd10, d, s); check(d == 32'h0, "R8", "no pending for wakeup", d, 32'h0);
    doWrite(4'd10, 32'h3FF, s);
    doRead(4'd10, d, s); check(d == 32'h0, "R8", "pending write ignored", d, 32'h0);
    funcCapture = 32'hCAFE_0001;
    doWrite(4'd13, 32'h9999_9999, s);
    doRead(4'd13, d, s); check(d == 32'hCAFE_0001, "R8", "capture write ignored", d, 32'hCAFE_0001);
  endtask

  task automatic testSnapshot();
    logic [31:0] d;
    int s;
    funcCounter = 32'h1234_5678;
    funcCapture = 32'h0BAD_F00D;
    doRead(4'd1, d, s);
    check(d == 32'h1234_5678, "R9", "counter snapshot", d, 32'h1234_5678);
    check(s > 0, "R9", "counter read waits", 32'(s), 32'h1);
    doRead(4'd13, d, s);
    check(d == 32'h0BAD_F00D, "R9", "capture snapshot", d, 32'h0BAD_F00D);
    funcCounter = 32'h8765_4321;
    doRead(4'd1, d, s);
    check(d == 32'h8765_4321, "R9", "counter snapshot updated", d, 32'h8765_4321);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    int s;
    doWrite(4'd1, 32'h0000_00C1, s);
    waitIdle();
    check(slice(1) == 32'hC1, "R10", "counter write reaches slice", slice(1), 32'hC1);
    doRead(4'd1, d, s);
    check(d == 32'h8765_4321, "R10", "counter read is live", d, 32'h8765_4321);
    doRead(4'd0, d, s);
    check(d == 32'hA5A5_0001 && s == 0, "R10", "reg0 readback", d, 32'hA5A5_0001);
    doRead(4'd2, d, s);
    check(d == 32'h3333_4444, "R10", "reg2 readback", d, 32'h3333_4444);
  endtask

  task automatic testUnused();
    logic [31:0] d;
    int s;
    doWrite(4'd14, 32'hFFFF_FFFF, s);
    doRead(4'd14, d, s); check(d == 32'h0, "R11", "addr14 reads zero", d, 32'h0);
    doRead(4'd15, d, s); check(d == 32'h0, "R11", "addr15 reads zero", d, 32'h0);
  endtask

  initial begin
    #600us;
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    busReq = 1'b0; busWe = 1'b0; busAddr = '0; busWData = '0;
    funcCounter = '0; funcCapture = '0;
    busRstN = 1'b0; funcRstN = 1'b0;
    repeat (4) @(negedge funcClk);
    @(negedge busClk);
    busRstN = 1'b1; funcRstN = 1'b1;
    testReset();
    testTiming();
    testHoldOff();
    testMulti();
    testNonPosted();
    testDirect();
    testSnapshot();
    testReadback();
    testUnused();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule